// File: doc/BRIEF.md
# Immediate Command/Response Register Block

This block gives software a way to push one 32-bit command word toward an attached serial codec and pick up one 32-bit response word, using a few memory-mapped registers instead of DMA ring buffers. Software loads a command register, then sets a busy bit. The block copies the command and offers it to the link transmitter with a valid/ready handshake. When the command is accepted, the block waits for a response from the link receiver. The first response that arrives is latched into a read-only response register. In the same clock update, the block sets a result-valid flag and clears busy.

Software polls the status register until busy drops or result-valid rises. It then reads the response and clears result-valid by writing a 1 to it. If a command never completes, software writes busy to 0 to abandon it and can then issue a new command. Broadcast commands are not supported on this path, and software must keep it idle while the ring-buffer mechanism is running. The block itself does not check either rule.

Top module: `imm_cmd_ctrl`

## Requirements
- R1: After reset, the command, response and status registers read as zero and `cmd_valid_o` is low.
- R2: The register map uses byte offsets. 0x0 holds the command (read/write). 0x4 holds the response (read-only; writes to it are ignored). 0x8 holds the status, where bit 0 is busy, bit 1 is result-valid, and bits 31:2 read as zero. Any other offset reads as zero.
- R3: Writing 1 to status bit 1 clears result-valid. Writing 0 to that bit leaves it unchanged.
- R4: A status write with bit 0 set while busy is 0 sets busy and raises `cmd_valid_o` on the next cycle. At that point `cmd_data_o` carries the command register value from the moment of the write.
- R5: While busy, a response accepted after the link took the command is latched into the response register. In the same update, result-valid becomes 1 and busy becomes 0.
- R6: A status write with bit 0 clear while busy abandons the command. `cmd_valid_o` drops, busy reads 0, and a later 0-to-1 write issues a fresh command.
- R7: When several response lanes are valid in the same cycle, only one word is latched: the one on the lowest-numbered lane.
- R8: A response that arrives while busy is 0, or before the link has accepted the command, changes neither the response register nor result-valid.
- R9: Writing 1 to busy while it is already 1 does not reissue the command.
- R10: `cmd_valid_o` and `cmd_data_o` stay steady until `cmd_ready_i` is high. Rewriting the command register meanwhile does not alter `cmd_data_o`. Once the link accepts the command, `cmd_valid_o` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset for reads and writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| cmd_valid_o | output | 1 | Command word offered to the link transmitter |
| cmd_ready_i | input | 1 | Link transmitter accepts the command |
| cmd_data_o | output | 32 | Command word being sent |
| rsp_valid_i | input | N_SRC | Per-lane response valid from the link receiver |
| rsp_data_i | input | N_SRC*32 | Per-lane response words, lane 0 in the low bits |

## Verification
The bench targets the following corner cases:

- **Response before acceptance.** It drives a response while the command is still waiting for `cmd_ready_i`. A design that captures too early would latch that stray word and finish the command before it was ever sent.
- **Idle response and stale completion.** It drives a response while the block is idle, and abandons a command in the middle of a transfer. A design that gets this wrong would overwrite the response register, or raise result-valid for a command that no longer exists.
- **Write-1 while busy and command rewrite.** It writes 1 to busy while busy is already set, and rewrites the command register while the command is still being offered. A design that lacks the edge detection or the snapshot would send a second command or change the word on the link in mid-handshake.
- **Simultaneous lanes.** It drives two response lanes in the same cycle. A design that ORs the lanes or picks the wrong lane would return a corrupted word.

// File: rtl/imm_pkg.sv
package imm_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned STAT_W    = 16;
  localparam int unsigned OFF_CMD   = 0;
  localparam int unsigned OFF_RESP  = 4;
  localparam int unsigned OFF_STAT  = 8;
  localparam int unsigned BIT_BUSY  = 0;
  localparam int unsigned BIT_RV    = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } imm_state_e;
endpackage

// File: rtl/imm_reg_dec.sv
module imm_reg_dec #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAT_W = 16,
  parameter logic [ADDR_W-1:0] A_CMD  = '0,
  parameter logic [ADDR_W-1:0] A_RESP = '0,
  parameter logic [ADDR_W-1:0] A_STAT = '0
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wbusy_i,
  input  logic              wrv_i,
  input  logic [DATA_W-1:0] cmd_q_i,
  input  logic [DATA_W-1:0] resp_q_i,
  input  logic              busy_i,
  input  logic              rv_i,
  output logic              cmd_we_o,
  output logic              issue_o,
  output logic              abandon_o,
  output logic              rv_clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              stat_we;
  logic [STAT_W-1:0] stat_rd;

  assign cmd_we_o  = we_i && (addr_i == A_CMD);
  assign stat_we   = we_i && (addr_i == A_STAT);
  assign issue_o   = stat_we && wbusy_i;
  assign abandon_o = stat_we && !wbusy_i;
  assign rv_clr_o  = stat_we && wrv_i;

  always_comb begin
    stat_rd = '0;
    stat_rd[imm_pkg::BIT_BUSY] = busy_i;
    stat_rd[imm_pkg::BIT_RV]   = rv_i;
  end

  always_comb begin
    unique case (addr_i)
      A_CMD:   rdata_o = cmd_q_i;
      A_RESP:  rdata_o = resp_q_i;
      A_STAT:  rdata_o = {{(DATA_W-STAT_W){1'b0}}, stat_rd};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/imm_hs_fsm.sv
module imm_hs_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic abandon_i,
  input  logic ready_i,
  input  logic rsp_hit_i,
  output logic load_o,
  output logic capture_o,
  output logic busy_o,
  output logic valid_o
);
  import imm_pkg::*;

  imm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (issue_i) state_d = ST_SEND;
      ST_SEND: begin
        if (abandon_i)    state_d = ST_IDLE;
        else if (ready_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (abandon_i)      state_d = ST_IDLE;
        else if (rsp_hit_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // only a 0->1 busy edge loads; abandon beats a same-cycle response
  assign load_o    = (state_q == ST_IDLE) && issue_i;
  assign capture_o = (state_q == ST_WAIT) && rsp_hit_i && !abandon_i;
  assign busy_o    = (state_q != ST_IDLE);
  assign valid_o   = (state_q == ST_SEND);
endmodule

// File: rtl/imm_rsp_sel.sv
module imm_rsp_sel #(
  parameter int unsigned N_SRC  = 2,
  parameter int unsigned DATA_W = 32
) (
  input  logic [N_SRC-1:0]        valid_i,
  input  logic [N_SRC*DATA_W-1:0] data_i,
  output logic                    hit_o,
  output logic [DATA_W-1:0]       data_o
);
  // lowest lane wins
  always_comb begin
    hit_o  = 1'b0;
    data_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (valid_i[i]) begin
        hit_o  = 1'b1;
        data_o = data_i[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/imm_cmd_ctrl.sv
module imm_cmd_ctrl #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned N_SRC  = 2,
  parameter int unsigned DATA_W = imm_pkg::DATA_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [DATA_W-1:0]       reg_wdata_i,
  output logic [DATA_W-1:0]       reg_rdata_o,
  output logic                    cmd_valid_o,
  input  logic                    cmd_ready_i,
  output logic [DATA_W-1:0]       cmd_data_o,
  input  logic [N_SRC-1:0]        rsp_valid_i,
  input  logic [N_SRC*DATA_W-1:0] rsp_data_i
);
  import imm_pkg::*;

  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_RESP = ADDR_W'(OFF_RESP);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);

  logic [DATA_W-1:0] cmd_q, tx_q, resp_q, rsp_word;
  logic              rv_q, busy, rsp_hit;
  logic              cmd_we, issue, abandon, rv_clr, load, capture;

  imm_reg_dec #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W),
    .A_CMD(A_CMD), .A_RESP(A_RESP), .A_STAT(A_STAT)
  ) u_dec (
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wbusy_i   (reg_wdata_i[BIT_BUSY]),
    .wrv_i     (reg_wdata_i[BIT_RV]),
    .cmd_q_i   (cmd_q),
    .resp_q_i  (resp_q),
    .busy_i    (busy),
    .rv_i      (rv_q),
    .cmd_we_o  (cmd_we),
    .issue_o   (issue),
    .abandon_o (abandon),
    .rv_clr_o  (rv_clr),
    .rdata_o   (reg_rdata_o)
  );

  imm_rsp_sel #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_sel (
    .valid_i (rsp_valid_i),
    .data_i  (rsp_data_i),
    .hit_o   (rsp_hit),
    .data_o  (rsp_word)
  );

  imm_hs_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .issue_i   (issue),
    .abandon_i (abandon),
    .ready_i   (cmd_ready_i),
    .rsp_hit_i (rsp_hit),
    .load_o    (load),
    .capture_o (capture),
    .busy_o    (busy),
    .valid_o   (cmd_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      tx_q   <= '0;
      resp_q <= '0;
      rv_q   <= 1'b0;
    end else begin
      if (cmd_we)  cmd_q  <= reg_wdata_i;
      if (load)    tx_q   <= cmd_q;
      if (capture) resp_q <= rsp_word;
      // a fresh result wins over a same-cycle clear
      if (capture)     rv_q <= 1'b1;
      else if (rv_clr) rv_q <= 1'b0;
    end
  end

  assign cmd_data_o = tx_q;
endmodule

// File: rtl/imm_cmd_ctrl_chk.sv
module imm_cmd_ctrl_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              wbusy_i,
  input logic [DATA_W-1:3] rd_hi_i,
  input logic              rd_b2_i,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [DATA_W-1:0] cmd_data_o,
  input logic              busy_i,
  input logic              rv_i,
  input logic [DATA_W-1:0] resp_i
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(imm_pkg::OFF_STAT);

  logic stat_wr;
  assign stat_wr = reg_we_i && (reg_addr_i == A_STAT);

  // R2: reserved status bits read zero
  a_r2_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_STAT) |-> (rd_hi_i == '0 && !rd_b2_i));

  // R4: idle issue raises valid next cycle
  a_r4_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && wbusy_i && !busy_i) |=> (cmd_valid_o && busy_i));

  // R5: busy falling without abandon means a result arrived
  a_r5_done_sets_rv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_i) && !$past(stat_wr && !wbusy_i)) |-> rv_i);

  // R8: idle block never changes the response
  a_r8_idle_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> $stable(resp_i));

  // R9: once the link took the command, no reissue without going idle
  a_r9_no_reissue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !cmd_valid_o) |=> !cmd_valid_o);

  // R10: command held until accepted
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i && !(stat_wr && !wbusy_i))
      |=> (cmd_valid_o && $stable(cmd_data_o)));
endmodule

bind imm_cmd_ctrl imm_cmd_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .wbusy_i     (reg_wdata_i[0]),
  .rd_hi_i     (reg_rdata_o[DATA_W-1:3]),
  .rd_b2_i     (reg_rdata_o[2]),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_data_o  (cmd_data_o),
  .busy_i      (busy),
  .rv_i        (rv_q),
  .resp_i      (resp_q)
);

// File: tb/imm_cmd_ctrl_tb.sv
module imm_cmd_ctrl_tb;
  localparam int unsigned AW = 4;
  localparam int unsigned NS = 2;
  localparam logic [3:0] CMD = 4'h0, RSP = 4'h4, STA = 4'h8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata, cmd_data;
  logic cmd_valid, ready = 1'b0;
  logic [NS-1:0] rsp_v = '0;
  logic [NS*32-1:0] rsp_d = '0;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  imm_cmd_ctrl #(.ADDR_W(AW), .N_SRC(NS)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cmd_valid_o(cmd_valid),
    .cmd_ready_i(ready), .cmd_data_o(cmd_data), .rsp_valid_i(rsp_v),
    .rsp_data_i(rsp_d)
  );

  typedef struct packed {
    logic        rd;
    logic [3:0]  a;
    logic [31:0] d;
  } vec_t;

  localparam vec_t TBL [14] = '{
    '{1'b0, 4'h0, 32'h1234_5678}, '{1'b1, 4'h0, 32'h1234_5678},
    '{1'b0, 4'h4, 32'hDEAD_BEEF}, '{1'b1, 4'h4, 32'h0000_0000},
    '{1'b0, 4'h8, 32'hFFFF_FFFC}, '{1'b1, 4'h8, 32'h0000_0000},
    '{1'b1, 4'hC, 32'h0000_0000}, '{1'b0, 4'h0, 32'hCAFE_F00D},
    '{1'b0, 4'h8, 32'h0000_0001}, '{1'b1, 4'h8, 32'h0000_0001},
    '{1'b0, 4'h8, 32'h0000_0001}, '{1'b1, 4'h8, 32'h0000_0001},
    '{1'b0, 4'h8, 32'h0000_0000}, '{1'b1, 4'h8, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic rsp_pulse(input logic [NS-1:0] v, input logic [31:0] d0, input logic [31:0] d1);
    @(negedge clk);
    rsp_v = v; rsp_d = {d1, d0};
    @(negedge clk);
    rsp_v = '0;
  endtask

  task automatic accept();
    @(negedge clk); ready = 1'b1;
    @(negedge clk); ready = 1'b0;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    rd("R1 cmd", CMD, 32'h0);
    rd("R1 resp", RSP, 32'h0);
    rd("R1 status", STA, 32'h0);
    chk("R1 cmd_valid", {31'h0, cmd_valid}, 32'h0);
    rst_ni = 1'b1;

    // R2 map, R3 write-0, R9 re-write busy, R6 abandon (table)
    foreach (TBL[i]) begin
      if (TBL[i].rd) rd($sformatf("R2/R9/R6 vec %0d", i), TBL[i].a, TBL[i].d);
      else           wr(TBL[i].a, TBL[i].d);
    end

    // R4 issue with snapshot, R10 hold
    wr(CMD, 32'hA5A5_0001);
    wr(STA, 32'h1);
    chk("R4 valid", {31'h0, cmd_valid}, 32'h1);
    chk("R4 data", cmd_data, 32'hA5A5_0001);
    wr(CMD, 32'h5A5A_0002);
    chk("R10 valid held", {31'h0, cmd_valid}, 32'h1);
    chk("R10 data held", cmd_data, 32'hA5A5_0001);
    // R8 response before acceptance ignored
    rsp_pulse(2'b01, 32'h0BAD_0BAD, 32'h0);
    rd("R8 early resp", RSP, 32'h0);
    rd("R8 early status", STA, 32'h1);
    accept();
    chk("R10 valid drops", {31'h0, cmd_valid}, 32'h0);
    rd("R10 still busy", STA, 32'h1);
    // R9 write-1 while busy in wait
    wr(STA, 32'h1);
    chk("R9 no reissue", {31'h0, cmd_valid}, 32'h0);
    // R5 completion
    rsp_pulse(2'b01, 32'h1357_9BDF, 32'h0);
    rd("R5 resp", RSP, 32'h1357_9BDF);
    rd("R5 status", STA, 32'h2);
    // R3 W1C
    wr(STA, 32'h0);
    rd("R3 write0 keeps", STA, 32'h2);
    wr(STA, 32'h2);
    rd("R3 w1c", STA, 32'h0);
    // R8 idle response ignored
    rsp_pulse(2'b11, 32'h7777_7777, 32'h8888_8888);
    rd("R8 idle resp", RSP, 32'h1357_9BDF);
    rd("R8 idle status", STA, 32'h0);

    // R7 both lanes: lowest lane
    wr(STA, 32'h1);
    accept();
    rsp_pulse(2'b11, 32'h1111_1111, 32'h2222_2222);
    rd("R7 lowest lane", RSP, 32'h1111_1111);
    wr(STA, 32'h2);
    // R7 lane 1 alone
    wr(STA, 32'h1);
    accept();
    rsp_pulse(2'b10, 32'h0, 32'h3333_3333);
    rd("R7 lane1", RSP, 32'h3333_3333);
    rd("R7 status", STA, 32'h2);
    wr(STA, 32'h2);

    // R6 abandon in wait, stale response ignored, reissue works
    wr(CMD, 32'h0F0F_0F0F);
    wr(STA, 32'h1);
    accept();
    wr(STA, 32'h0);
    rd("R6 abandoned", STA, 32'h0);
    rsp_pulse(2'b01, 32'hEEEE_EEEE, 32'h0);
    rd("R6 stale resp", RSP, 32'h3333_3333);
    wr(STA, 32'h1);
    chk("R6 reissue valid", {31'h0, cmd_valid}, 32'h1);
    chk("R6 reissue data", cmd_data, 32'h0F0F_0F0F);
    // R6 abandon during send
    wr(STA, 32'h0);
    chk("R6 send abandon", {31'h0, cmd_valid}, 32'h0);
    rd("R6 send abandon st", STA, 32'h0);

    done = 1'b1;
    report();
  end
endmodule